// File: doc/BRIEF.md
# Lane Execution-Mask Unit

This unit holds the per-lane enable mask of a 64-lane vector engine and carries out the scalar mask operations that a compiler uses to lower divergent control flow. A set bit lets its lane execute; a clear bit parks it. The unit takes one mask operation per clock. An operation may read the current mask and return it as a scalar result in the same step as it writes a new mask. With that, if/else, loops with breaks and nested regions each reduce to a short fixed sequence of mask operations.

Every operation takes up to three 64-bit operands: the lane compare result, a scalar source (a mask saved earlier or an accumulated break set), and the per-lane sign flags used by kill. The unit returns the mask, a scalar result with its write strobe, and a branch decision. The scalar register file, the program counter and the lanes themselves sit outside.

Top module: `lane_mask_unit`

## Requirements
- R1: After reset (rst_n low, synchronous) the mask reads all ones.
- R2: Opcode 0 (save-and-narrow) drives sdst with the current mask and raises sdst_we in the same cycle. At the next edge the mask becomes the current mask AND cmp_mask.
- R3: Opcode 1 (save-and-widen) drives sdst with the current mask and raises sdst_we in the same cycle. At the next edge the mask becomes the current mask OR src_mask.
- R4: Opcode 2 drives sdst with src_mask XOR the current mask and raises sdst_we, and the mask does not change. Opcode 3 sets the mask to src_mask XOR the current mask, with sdst_we low.
- R5: Opcode 4 (region rejoin) sets the mask to the current mask OR src_mask, with sdst_we low.
- R6: Opcode 5 (loop end) sets the mask to the current mask AND NOT src_mask. In that same cycle branch_taken is high exactly when this new mask is non-zero.
- R7: Opcode 6 (break accumulate) drives sdst with the current mask OR src_mask and raises sdst_we, and the mask does not change.
- R8: Opcode 7 raises branch_taken exactly when the current mask is all zero. Opcode 8 raises it exactly when the mask is non-zero. Neither opcode changes the mask or raises sdst_we.
- R9: Opcode 9 (kill) clears each mask bit whose sign_flags bit is set and keeps every other bit. sdst_we stays low.
- R10: With op_valid low, or with an unassigned opcode (10 to 15), the mask holds and sdst_we and branch_taken stay low.
- R11: branch_taken is low for every opcode other than 5, 7 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code |
| cmp_mask | input | 64 | Per-lane compare result |
| src_mask | input | 64 | Scalar source operand |
| sign_flags | input | 64 | Per-lane negative flags for kill |
| exec_mask | output | 64 | Current execution mask |
| sdst | output | 64 | Scalar result |
| sdst_we | output | 1 | Scalar result write strobe |
| branch_taken | output | 1 | Branch decision of the current operation |

## Verification
sdst, sdst_we and branch_taken are combinational from the operation presented and the mask held in the register. They are due in the same cycle, and the bench samples them one time unit after driving inputs on the falling edge. The new mask appears one register later. The bench reads exec_mask one time unit after the following rising edge and compares it with a model mask that it updates from the requirement formulas. The sweep runs every opcode, including the unassigned ones and op_valid low. It also drives the mask to all zero and back, so that both branch tests and the loop-end test see the zero boundary.

// File: rtl/lane_mask_pkg.sv
// Shared opcode encoding for the lane execution-mask unit.
// Assumes a 4-bit opcode field; codes 10..15 are unassigned.
package lane_mask_pkg;
    typedef enum logic [3:0] {
        OP_SAVE_AND   = 4'd0,
        OP_SAVE_OR    = 4'd1,
        OP_XOR_SDST   = 4'd2,
        OP_XOR_MASK   = 4'd3,
        OP_REJOIN     = 4'd4,
        OP_LOOP_END   = 4'd5,
        OP_BREAK_ACC  = 4'd6,
        OP_BR_ZERO    = 4'd7,
        OP_BR_NONZERO = 4'd8,
        OP_KILL       = 4'd9
    } mask_op_e;

    typedef enum logic [1:0] {
        TEST_NONE    = 2'd0,
        TEST_ZERO    = 2'd1,
        TEST_NONZERO = 2'd2
    } test_sel_e;
endpackage

// File: rtl/mask_alu.sv
// Combinational decode and datapath of the mask operations.
// Computes the next mask, its load enable, the scalar result and the
// branch test to apply. Assumes op_code holds a valid code only when op_valid is high.
module mask_alu
    import lane_mask_pkg::*;
#(
    parameter int LANES = 64
) (
    input  logic             op_valid,
    input  logic [3:0]       op_code,
    input  logic [LANES-1:0] cur_mask,
    input  logic [LANES-1:0] cmp_mask,
    input  logic [LANES-1:0] src_mask,
    input  logic [LANES-1:0] sign_flags,
    output logic [LANES-1:0] nxt_mask,
    output logic             mask_load,
    output logic [LANES-1:0] sdst,
    output logic             sdst_we,
    output logic [LANES-1:0] test_val,
    output test_sel_e        test_sel
);
    logic [LANES-1:0] killed;

    // Per-lane kill: a lane survives only if its sign flag is clear.
    for (genvar g = 0; g < LANES; g++) begin : g_kill
        assign killed[g] = cur_mask[g] & ~sign_flags[g];
    end

    // Decode the opcode into mask update, scalar result and branch test.
    always_comb begin
        nxt_mask  = cur_mask;
        mask_load = 1'b0;
        sdst      = '0;
        sdst_we   = 1'b0;
        test_val  = cur_mask;
        test_sel  = TEST_NONE;
        if (op_valid) begin
            case (op_code)
                OP_SAVE_AND: begin
                    sdst      = cur_mask;
                    sdst_we   = 1'b1;
                    nxt_mask  = cur_mask & cmp_mask;
                    mask_load = 1'b1;
                end
                OP_SAVE_OR: begin
                    sdst      = cur_mask;
                    sdst_we   = 1'b1;
                    nxt_mask  = cur_mask | src_mask;
                    mask_load = 1'b1;
                end
                OP_XOR_SDST: begin
                    sdst    = src_mask ^ cur_mask;
                    sdst_we = 1'b1;
                end
                OP_XOR_MASK: begin
                    nxt_mask  = src_mask ^ cur_mask;
                    mask_load = 1'b1;
                end
                OP_REJOIN: begin
                    nxt_mask  = cur_mask | src_mask;
                    mask_load = 1'b1;
                end
                OP_LOOP_END: begin
                    nxt_mask  = cur_mask & ~src_mask;
                    mask_load = 1'b1;
                    test_val  = cur_mask & ~src_mask;
                    test_sel  = TEST_NONZERO;
                end
                OP_BREAK_ACC: begin
                    sdst    = cur_mask | src_mask;
                    sdst_we = 1'b1;
                end
                OP_BR_ZERO:    test_sel = TEST_ZERO;
                OP_BR_NONZERO: test_sel = TEST_NONZERO;
                OP_KILL: begin
                    nxt_mask  = killed;
                    mask_load = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/zero_test.sv
// Branch decision: tests a mask value for all-zero or non-zero.
// Assumes the select is TEST_NONE for non-branch operations.
module zero_test
    import lane_mask_pkg::*;
#(
    parameter int LANES = 64
) (
    input  logic [LANES-1:0] value,
    input  test_sel_e        sel,
    output logic             taken
);
    logic any_set;

    // Reduce the mask to a single non-zero flag.
    assign any_set = |value;

    // Pick the polarity that the selected test asks for.
    always_comb begin
        case (sel)
            TEST_ZERO:    taken = ~any_set;
            TEST_NONZERO: taken = any_set;
            default:      taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/mask_reg.sv
// Execution-mask register with load enable and all-ones reset.
// Assumes synchronous active-low reset.
module mask_reg #(
    parameter int LANES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LANES-1:0] d,
    output logic [LANES-1:0] q
);
    // Hold the mask; reset enables every lane.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '1;
        else if (load) q <= d;
    end
endmodule

// File: rtl/lane_mask_unit.sv
// Top of the lane execution-mask unit. One mask operation per clock.
// Scalar result and branch decision are combinational in the operation's
// cycle; the new mask is visible after the next rising edge.
module lane_mask_unit
    import lane_mask_pkg::*;
#(
    parameter int LANES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [3:0]       op_code,
    input  logic [LANES-1:0] cmp_mask,
    input  logic [LANES-1:0] src_mask,
    input  logic [LANES-1:0] sign_flags,
    output logic [LANES-1:0] exec_mask,
    output logic [LANES-1:0] sdst,
    output logic             sdst_we,
    output logic             branch_taken
);
    logic [LANES-1:0] nxt_mask;
    logic             mask_load;
    logic [LANES-1:0] test_val;
    test_sel_e        test_sel;

    mask_alu #(.LANES(LANES)) alu_i (
        .op_valid   (op_valid),
        .op_code    (op_code),
        .cur_mask   (exec_mask),
        .cmp_mask   (cmp_mask),
        .src_mask   (src_mask),
        .sign_flags (sign_flags),
        .nxt_mask   (nxt_mask),
        .mask_load  (mask_load),
        .sdst       (sdst),
        .sdst_we    (sdst_we),
        .test_val   (test_val),
        .test_sel   (test_sel)
    );

    zero_test #(.LANES(LANES)) test_i (
        .value (test_val),
        .sel   (test_sel),
        .taken (branch_taken)
    );

    mask_reg #(.LANES(LANES)) reg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mask_load),
        .d     (nxt_mask),
        .q     (exec_mask)
    );
endmodule

// File: rtl/lane_mask_unit_chk.sv
// Property checker for lane_mask_unit, attached by bind.
// Relates the ports over time; assumes synchronous active-low reset.
module lane_mask_unit_chk #(
    parameter int LANES = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [3:0]       op_code,
    input logic [LANES-1:0] cmp_mask,
    input logic [LANES-1:0] src_mask,
    input logic [LANES-1:0] sign_flags,
    input logic [LANES-1:0] exec_mask,
    input logic [LANES-1:0] sdst,
    input logic             sdst_we,
    input logic             branch_taken
);
    AST_SAVE_AND_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd0) |=> exec_mask == ($past(exec_mask) & $past(cmp_mask))); // R2
    AST_SAVE_OR_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd1) |-> (sdst_we && sdst == exec_mask)); // R3
    AST_BREAK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd6) |=> $stable(exec_mask)); // R7
    AST_LOOP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd5) |=> (exec_mask != '0) == $past(branch_taken)); // R6
    AST_BR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd7) |-> branch_taken == (exec_mask == '0)); // R8
    AST_KILL_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd9) |=> (exec_mask & ~$past(exec_mask)) == '0); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(exec_mask)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> (!sdst_we && !branch_taken)); // R10
endmodule

bind lane_mask_unit lane_mask_unit_chk #(.LANES(LANES)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_code      (op_code),
    .cmp_mask     (cmp_mask),
    .src_mask     (src_mask),
    .sign_flags   (sign_flags),
    .exec_mask    (exec_mask),
    .sdst         (sdst),
    .sdst_we      (sdst_we),
    .branch_taken (branch_taken)
);

// File: tb/lane_mask_unit_tb_top.sv
// Self-checking bench: sweeps all opcodes over random and boundary masks.
module lane_mask_unit_tb_top;
    localparam int LANES = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             op_valid = 1'b0;
    logic [3:0]       op_code = '0;
    logic [LANES-1:0] cmp_mask = '0;
    logic [LANES-1:0] src_mask = '0;
    logic [LANES-1:0] sign_flags = '0;
    logic [LANES-1:0] exec_mask;
    logic [LANES-1:0] sdst;
    logic             sdst_we;
    logic             branch_taken;

    int checks = 0;
    int errors = 0;
    logic [LANES-1:0] model = '1;

    always #2 clk = ~clk;

    lane_mask_unit #(.LANES(LANES)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .cmp_mask(cmp_mask), .src_mask(src_mask), .sign_flags(sign_flags),
        .exec_mask(exec_mask), .sdst(sdst), .sdst_we(sdst_we),
        .branch_taken(branch_taken)
    );

    function automatic string tag_of(input logic v, input logic [3:0] op);
        if (!v) return "R10";
        case (op)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2, 4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            4'd7, 4'd8: return "R8";
            4'd9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check64(input string tag, input string what,
                           input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input logic v, input logic [3:0] op, input logic [LANES-1:0] c,
                         input logic [LANES-1:0] s, input logic [LANES-1:0] k);
        logic [LANES-1:0] e_nxt, e_sdst;
        logic e_we, e_tk;
        string tag;
        @(negedge clk);
        op_valid = v; op_code = op; cmp_mask = c; src_mask = s; sign_flags = k;
        e_nxt = model; e_sdst = '0; e_we = 1'b0; e_tk = 1'b0;
        if (v) begin
            case (op)
                4'd0: begin e_sdst = model; e_we = 1'b1; e_nxt = model & c; end
                4'd1: begin e_sdst = model; e_we = 1'b1; e_nxt = model | s; end
                4'd2: begin e_sdst = model ^ s; e_we = 1'b1; end
                4'd3: e_nxt = model ^ s;
                4'd4: e_nxt = model | s;
                4'd5: begin e_nxt = model & ~s; e_tk = (e_nxt != '0); end
                4'd6: begin e_sdst = model | s; e_we = 1'b1; end
                4'd7: e_tk = (model == '0);
                4'd8: e_tk = (model != '0);
                4'd9: e_nxt = model & ~k;
                default: ;
            endcase
        end
        tag = tag_of(v, op);
        #1;
        check64(tag, "sdst_we", {63'd0, sdst_we}, {63'd0, e_we});
        if (e_we) check64(tag, "sdst", sdst, e_sdst);
        // R11: no branch decision outside the branch and loop-end codes
        check64((v && (op == 4'd5 || op == 4'd7 || op == 4'd8)) ? tag : "R11",
                "branch_taken", {63'd0, branch_taken}, {63'd0, e_tk});
        @(posedge clk);
        #1;
        model = e_nxt;
        check64(tag, "exec_mask", exec_mask, model);
    endtask

    function automatic logic [LANES-1:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check64("R1", "reset mask", exec_mask, '1);
        model = '1;
        // Boundary: mask to zero via XOR with itself, then test branches.
        apply(1'b1, 4'd7, '0, '0, '0);
        apply(1'b1, 4'd8, '0, '0, '0);
        apply(1'b1, 4'd3, '0, model, '0);
        apply(1'b1, 4'd7, '0, '0, '0);
        apply(1'b1, 4'd8, '0, '0, '0);
        apply(1'b1, 4'd5, '0, '0, '0);
        apply(1'b1, 4'd4, '0, 64'h8000_0000_0000_0001, '0);
        apply(1'b1, 4'd5, '0, 64'h0000_0000_0000_0001, '0);
        apply(1'b1, 4'd5, '0, 64'h8000_0000_0000_0000, '0);
        apply(1'b1, 4'd1, '0, '1, '0);
        apply(1'b1, 4'd9, '0, '0, 64'hFFFF_0000_0000_FFFF);
        apply(1'b1, 4'd0, 64'h0F0F_0F0F_0F0F_0F0F, '0, '0);
        // Sweep every opcode, with and without op_valid, over random operands.
        for (int r = 0; r < 60; r++) begin
            for (int op = 0; op < 16; op++) begin
                apply(1'b1, op[3:0], rnd64() | rnd64(), rnd64() & rnd64(), rnd64() & rnd64());
                apply(1'b0, op[3:0], rnd64(), rnd64(), rnd64());
            end
            if (model == '0) apply(1'b1, 4'd1, '0, rnd64(), '0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule